// File: doc/BRIEF.md
# Translation Buffer Control Register with Replacement Pointer

This block is the control register that sits beside a processor's address translation buffers. It holds a 6-bit replacement pointer. The pointer names the entry of the unified translation buffer that the next software load-entry operation overwrites. The pointer steps forward on every translation lookup. Software can set an upper boundary, and the pointer then wraps back to zero when it reaches that boundary.

The same register carries several mode bits:
- a store-queue privilege bit;
- a bit that selects single or multiple virtual address space;
- a translation enable bit.

It also has a self-clearing invalidate bit. Writing one to that bit sends a one-cycle pulse to clear every valid bit in both translation buffers.

Software reads and writes the whole word through a simple register port. The buffers drive two strobes into the block, one for each lookup and one for each load-entry operation. The block drives decoded mode outputs back to the buffers and to the exception logic.

Top module: `tlb_ctrl_reg`

## Requirements
- R1: After a synchronous reset, the whole register reads as 0, the pointer is 0, and `inval_pulse`, `sq_addr_err`, `mmu_fault_out` and `proto_err` are low.
- R2: With the boundary at 0, each cycle with `tlb_access` high (and no write, no `tlb_load`) raises the pointer by one. The pointer wraps from 6'h3F to 0.
- R3: With a nonzero boundary, a lookup while the pointer equals the boundary sets the pointer to 0 instead of advancing it.
- R4: If software writes a pointer value at or above a nonzero boundary, lookups take the pointer on up to 6'h3F before it wraps to 0.
- R5: The pointer holds its value in any cycle where `tlb_load` is high, even if `tlb_access` is also high.
- R6: A write with bit 2 set drives `inval_pulse` high for exactly the one cycle after the write. Bit 2 always reads as 0.
- R7: Bit 9 is the store-queue privilege bit. When it is 1, `sq_addr_err` follows `sq_user_access`; when it is 0, `sq_addr_err` stays low. Bit 8 is the virtual-space mode bit, output on `single_vspace` (1 = single, 0 = multiple).
- R8: Bit 0 is the translation enable, output on `xlat_en`. `mmu_fault_out` equals `mmu_fault_req` while bit 0 is 1, and stays low while it is 0.
- R9: Bits 31:24, 17:16, 7:3 and 1 read as 0, and writing to them has no effect.
- R10: The boundary is a 6-bit field in bits 23:18. It resets to 0, and a value of 0 turns the early wrap off. The pointer sits in bits 15:10.
- R11: If a register write and a lookup fall in the same cycle, the written pointer value is what gets stored.
- R12: A write that changes bit 8 without also setting bit 2 sets `proto_err`. Once set, `proto_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| tlb_access | input | 1 | One translation lookup this cycle |
| tlb_load | input | 1 | Software load-entry operation this cycle |
| repl_idx | output | 6 | Current replacement pointer |
| inval_pulse | output | 1 | One-cycle clear of all valid bits |
| sq_priv_only | output | 1 | Store queues are limited to privileged mode |
| single_vspace | output | 1 | Single virtual address space selected |
| xlat_en | output | 1 | Address translation enabled |
| sq_user_access | input | 1 | A user-mode store-queue access is being made |
| sq_addr_err | output | 1 | Address error for a user store-queue access |
| mmu_fault_req | input | 1 | Raw MMU exception request |
| mmu_fault_out | output | 1 | Gated MMU exception request |
| proto_err | output | 1 | Sticky: mode bit changed without invalidate |

## Verification
If the pointer holds a wrong value, it shows on `repl_idx` and in bits 15:10 of `rd_data` in the very next cycle. A wrong boundary compare shows only when the pointer reaches the boundary, so the stimulus runs the pointer onto the boundary, past it, and through 6'h3F. A stale or stuck invalidate flop shows on `inval_pulse` one cycle after the write that should have caused the pulse. Wrong mode bits show as soon as their gating inputs toggle. The reference model is compared against every output on every clock, so any difference is caught in the cycle it first appears.

// File: rtl/tcr_pkg.sv
// Package: shared field layout of the translation control register.
// Assumes a 32-bit register word; the positions are fixed by the decode in neighbours.
package tcr_pkg;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 6;
    localparam int CNT_LSB = 10;
    localparam int BND_LSB = 18;
    localparam int SQ_BIT  = 9;
    localparam int SV_BIT  = 8;
    localparam int TI_BIT  = 2;
    localparam int AT_BIT  = 0;
    localparam logic [DATA_W-1:0] RSV_MASK = 32'hFF0300FA;

    typedef struct packed {
        logic sq_priv;
        logic single_vs;
        logic xlat;
    } mode_t;
endpackage

// File: rtl/tcr_repl_counter.sv
// Module: replacement pointer. Counts lookups, wraps at a programmable boundary
// (0 = no boundary), holds during load-entry, and takes a software write first.
// Assumes the write, load and access strobes are synchronous to clk.
module tcr_repl_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_en,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] bnd,
    input  logic         access,
    input  logic         hold,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic at_bnd;
    logic [W-1:0] cnt_nxt;

    // Purpose: detect that the pointer sits on an enabled boundary.
    always_comb at_bnd = (bnd != ZERO) && (cnt == bnd);

    // Purpose: pick the next pointer value by priority write > hold > step.
    always_comb begin
        cnt_nxt = cnt;
        if (ld_en)
            cnt_nxt = ld_val;
        else if (hold)
            cnt_nxt = cnt;
        else if (access)
            cnt_nxt = at_bnd ? ZERO : cnt + ONE;
    end

    // Purpose: pointer register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= ZERO;
        else        cnt <= cnt_nxt;
    end

    AST_CNT_HOLD_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && hold) |=> $stable(cnt)); // R5
    AST_CNT_WRAP_AT_BND: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !hold && access && bnd != ZERO && cnt == bnd) |=> (cnt == ZERO)); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !hold && access && !(bnd != ZERO && cnt == bnd)) |=> (cnt == $past(cnt) + ONE)); // R2
    AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (cnt == $past(ld_val))); // R11
endmodule

// File: rtl/tcr_mode_regs.sv
// Module: mode bits, boundary field, invalidate pulse and sticky protocol check.
// Assumes a write presents the whole register word; the invalidate bit is not stored.
module tcr_mode_regs
    import tcr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_bnd,
    input  logic         wr_sq,
    input  logic         wr_sv,
    input  logic         wr_ti,
    input  logic         wr_at,
    output logic [W-1:0] bnd,
    output mode_t        mode,
    output logic         inval,
    output logic         perr
);
    logic sv_change_bad;

    // Purpose: flag a virtual-space mode change that lacks the invalidate bit.
    always_comb sv_change_bad = wr_en && (wr_sv != mode.single_vs) && !wr_ti;

    // Purpose: stored mode bits and boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bnd  <= '0;
            mode <= '0;
        end else if (wr_en) begin
            bnd            <= wr_bnd;
            mode.sq_priv   <= wr_sq;
            mode.single_vs <= wr_sv;
            mode.xlat      <= wr_at;
        end
    end

    // Purpose: one-cycle invalidate pulse following a write with the bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) inval <= 1'b0;
        else        inval <= wr_en && wr_ti;
    end

    // Purpose: sticky protocol error, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)             perr <= 1'b0;
        else if (sv_change_bad) perr <= 1'b1;
    end

    AST_INVAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inval) |-> $past(wr_en && wr_ti)); // R6
    AST_INVAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (inval && !$past(wr_en && wr_ti, 1)) |-> 1'b0 || $past(wr_en && wr_ti)); // R6
    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        perr |=> perr); // R12
    AST_BND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bnd)); // R10
endmodule

// File: rtl/tlb_ctrl_reg.sv
// Module: top of the translation control register. Assembles the read word,
// gates the exception outputs, and ties the pointer and mode sub-blocks together.
// Assumes reads are combinational from the current register state.
module tlb_ctrl_reg
    import tcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tlb_access,
    input  logic              tlb_load,
    output logic [CNT_W-1:0]  repl_idx,
    output logic              inval_pulse,
    output logic              sq_priv_only,
    output logic              single_vspace,
    output logic              xlat_en,
    input  logic              sq_user_access,
    output logic              sq_addr_err,
    input  logic              mmu_fault_req,
    output logic              mmu_fault_out,
    output logic              proto_err
);
    logic [CNT_W-1:0] bnd;
    mode_t            mode;

    tcr_repl_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (wr_en),
        .ld_val (wr_data[CNT_LSB +: CNT_W]),
        .bnd    (bnd),
        .access (tlb_access),
        .hold   (tlb_load),
        .cnt    (repl_idx)
    );

    tcr_mode_regs #(.W(CNT_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_bnd (wr_data[BND_LSB +: CNT_W]),
        .wr_sq  (wr_data[SQ_BIT]),
        .wr_sv  (wr_data[SV_BIT]),
        .wr_ti  (wr_data[TI_BIT]),
        .wr_at  (wr_data[AT_BIT]),
        .bnd    (bnd),
        .mode   (mode),
        .inval  (inval_pulse),
        .perr   (proto_err)
    );

    // Purpose: decoded mode outputs.
    always_comb begin
        sq_priv_only  = mode.sq_priv;
        single_vspace = mode.single_vs;
        xlat_en       = mode.xlat;
    end

    // Purpose: gate the exception-related outputs with the mode bits.
    always_comb begin
        sq_addr_err   = sq_user_access && mode.sq_priv;
        mmu_fault_out = mmu_fault_req && mode.xlat;
    end

    // Purpose: assemble the read word; reserved bits and invalidate read as 0.
    always_comb begin
        rd_data = '0;
        rd_data[BND_LSB +: CNT_W] = bnd;
        rd_data[CNT_LSB +: CNT_W] = repl_idx;
        rd_data[SQ_BIT]           = mode.sq_priv;
        rd_data[SV_BIT]           = mode.single_vs;
        rd_data[AT_BIT]           = mode.xlat;
    end

    AST_NO_FAULT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_en |-> !mmu_fault_out); // R8
    AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_data & RSV_MASK) != '0)) |=> ((rd_data & RSV_MASK) == '0)); // R9
    AST_TI_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[TI_BIT]) |=> !rd_data[TI_BIT]); // R6
endmodule

// File: tb/tb_tlb_ctrl_reg.sv
// Bench: behavioural reference model compared against the design on every clock.
module tb_tlb_ctrl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tlb_access = 1'b0, tlb_load = 1'b0;
    logic [5:0]  repl_idx;
    logic        inval_pulse, sq_priv_only, single_vspace, xlat_en;
    logic        sq_user_access = 1'b0, sq_addr_err;
    logic        mmu_fault_req = 1'b0, mmu_fault_out, proto_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    tlb_ctrl_reg dut (.*);

    always #10 clk = ~clk;   // 50 MHz

    // Reference model state (plain integers)
    int m_cnt, m_bnd, m_sq, m_sv, m_at, m_inv, m_perr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_bnd = 0; m_sq = 0; m_sv = 0; m_at = 0; m_inv = 0; m_perr = 0;
        end else begin
            int nb;
            nb = m_bnd;
            if (wr_en) m_cnt = (wr_data >> 10) & 63;
            else if (tlb_load) m_cnt = m_cnt;
            else if (tlb_access) m_cnt = (m_bnd != 0 && m_cnt == m_bnd) ? 0 : (m_cnt + 1) % 64;
            m_inv = (wr_en && wr_data[2]) ? 1 : 0;
            if (wr_en && (int'(wr_data[8]) != m_sv) && !wr_data[2]) m_perr = 1;
            if (wr_en) begin
                nb = (wr_data >> 18) & 63;
                m_sq = wr_data[9]; m_sv = wr_data[8]; m_at = wr_data[0];
            end
            m_bnd = nb;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_rd;
            exp_rd = (m_bnd << 18) | (m_cnt << 10) | (m_sq << 9) | (m_sv << 8) | m_at;
            chk(rd_data, exp_rd, "R9/R10 rd_data");
            chk(repl_idx, m_cnt, "R2 repl_idx");
            chk(inval_pulse, m_inv, "R6 inval_pulse");
            chk(sq_addr_err, int'(sq_user_access) & m_sq, "R7 sq_addr_err");
            chk(single_vspace, m_sv, "R7 single_vspace");
            chk(mmu_fault_out, int'(mmu_fault_req) & m_at, "R8 mmu_fault_out");
            chk(proto_err, m_perr, "R12 proto_err");
        end
    end

    task automatic step(input bit w, input logic [31:0] d, input bit acc, input bit ld);
        @(posedge clk); #2;
        wr_en = w; wr_data = d; tlb_access = acc; tlb_load = ld;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0);
    endtask

    task automatic look(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 1, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data, 0, "R1 reset rd_data");
        chk(proto_err, 0, "R1 reset proto_err");
        // R2: free-running wrap through 3F
        look(70);
        step(0, '0, 0, 0); @(negedge clk);
        chk(repl_idx, 70 % 64, "R2 wrap 3F->0");
        // R3: boundary 4, pointer 3
        step(1, (32'd4 << 18) | (32'd3 << 10), 0, 0);
        look(2); step(0, '0, 0, 0); @(negedge clk);
        chk(repl_idx, 0, "R3 boundary wrap");
        // R4: write beyond boundary runs to 3F then 0
        step(1, (32'd32 << 18) | (32'd62 << 10), 0, 0);
        look(1); step(0, '0, 0, 0); @(negedge clk);
        chk(repl_idx, 63, "R4 past boundary");
        look(1); step(0, '0, 0, 0); @(negedge clk);
        chk(repl_idx, 0, "R4 wrap after 3F");
        // R5: load holds, even with access
        look(3);
        step(0, '0, 1, 1); step(0, '0, 0, 1); step(0, '0, 0, 0); @(negedge clk);
        chk(repl_idx, 3, "R5 hold on load");
        // R11: write with access same cycle
        step(1, (32'd32 << 18) | (32'd17 << 10), 1, 0);
        step(0, '0, 0, 0); @(negedge clk);
        chk(repl_idx, 17, "R11 write wins");
        // R9: reserved bits ignored
        step(1, 32'hFF0300FA | (32'd32 << 18), 0, 0);
        step(0, '0, 0, 0); @(negedge clk);
        chk(rd_data & 32'hFF0300FF, 0, "R9 reserved");
        // R6: invalidate pulse
        step(1, 32'h4, 0, 0); @(negedge clk);
        chk(inval_pulse, 0, "R6 pulse not early");
        step(0, '0, 0, 0); @(negedge clk);
        chk(inval_pulse, 1, "R6 pulse");
        chk(rd_data[2], 0, "R6 reads zero");
        step(0, '0, 0, 0); @(negedge clk);
        chk(inval_pulse, 0, "R6 one cycle");
        // R7 / R8: gating
        step(0, '0, 0, 0); sq_user_access = 1; mmu_fault_req = 1; @(negedge clk);
        chk(sq_addr_err, 0, "R7 sq open");
        chk(mmu_fault_out, 0, "R8 fault off");
        step(1, 32'h0000_0201, 0, 0); step(0, '0, 0, 0); @(negedge clk);
        chk(sq_addr_err, 1, "R7 sq privileged");
        chk(mmu_fault_out, 1, "R8 fault on");
        chk(xlat_en, 1, "R8 xlat_en");
        sq_user_access = 0; mmu_fault_req = 0;
        // R12: mode change with invalidate is fine, without it is an error
        step(1, 32'h0000_0104, 0, 0); step(0, '0, 0, 0); @(negedge clk);
        chk(proto_err, 0, "R12 legal change");
        chk(single_vspace, 1, "R7 single mode");
        step(1, 32'h0, 0, 0); idle(2); @(negedge clk);
        chk(proto_err, 1, "R12 sticky set");
        step(1, 32'h0000_0004, 0, 0); idle(2); @(negedge clk);
        chk(proto_err, 1, "R12 stays set");
        // R1: reset clears everything again
        @(posedge clk); #2 rst_n = 1'b0;
        @(posedge clk); #2 rst_n = 1'b1;
        @(negedge clk);
        chk(proto_err, 0, "R1 reset clears error");
        chk(rd_data, 0, "R1 reset rd_data again");
        look(5); idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule